// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block sits in the fast source-clock domain next to the dividers that produce two clock banks, called A and C. Each bank divider has a phase counter, and the bank clock rises in the source cycle where that counter is zero. The ratio between the two bank periods need not be a whole number, so their rising edges line up only now and then. The block reads both divide ratios and both phase counters. Before each instant where the A and C rising edges line up, it drives an active-low warning pulse, `syncN`.

The pulse is sized and placed by the faster of the two banks. It goes low on a rising edge of the faster bank and stays low for exactly one period of that bank. It rises again in the source cycle where both banks rise together. When the two ratios are equal, every edge lines up. In that case only every second edge is marked, so the output is a square wave at half the bank rate. A freeze input forces the output low. The output is registered.

Top module: `coinc_sync_gen`

## Requirements
- R1: While reset is asserted, and in the first source cycle after it is released, `syncN` is high.
- R2: Each low pulse that no freeze touches lasts exactly F source cycles, where F = min(divA, divC).
- R3: A rising edge of `syncN` that no freeze caused happens only in a source cycle where `phaseA` and `phaseC` are both zero, which is a coincident rising edge of the A and C banks.
- R4: A low pulse that no freeze caused begins in a source cycle where the faster bank's phase counter is zero. The faster bank is A when divA <= divC, and C otherwise.
- R5: With divA != divC, and with t counting source cycles since reset and L = lcm(divA, divC), `syncN` is low exactly when (t mod L) >= L - F. This gives one pulse per coincidence and no pulse before a rising edge of the faster bank that does not line up.
- R6: With divA == divC = d, `syncN` is low exactly when (t mod 2d) >= d. The first bank period after reset is high, and every second period after that is low.
- R7: When `freeze` is 1 in a source cycle, `syncN` is 0 in the next cycle. After `freeze` returns to 0, the output follows R5 or R6 again from the next cycle.
- R8: R5 holds with either bank as the faster one, including fractional ratios such as 3:2 and 4:3 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock shared with the bank dividers |
| rstN | input | 1 | Asynchronous active-low reset, asserted together with the bank dividers |
| divA | input | W | Divide ratio of bank A in source cycles (1 or more) |
| divC | input | W | Divide ratio of bank C in source cycles (1 or more) |
| phaseA | input | W | Bank A phase counter, counting 0 to divA-1; bank A rises at 0 |
| phaseC | input | W | Bank C phase counter, counting 0 to divC-1; bank C rises at 0 |
| freeze | input | 1 | When 1, holds `syncN` low from the next cycle |
| syncN | output | 1 | Registered active-low sync pulse |

## Verification
The assertions rely on the two phase counters advancing by one each source cycle, wrapping at their divide ratios, and restarting from zero at the same reset as this block. They also rely on both divide ratios staying fixed between resets. The bench models the dividers itself. It changes the ratios only while reset is held and derives both phases from a single cycle count, so these conditions always hold. Because freeze can cut or extend a pulse, the width and alignment checks leave out any pulse that a freeze touched. The bench covers the frozen stretches and their release separately.

// File: rtl/coinc_sync_pkg.sv
package coinc_sync_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic aIsFast;     // bank A has the shorter period (or the same)
    logic equalMode;   // both banks share one ratio
    logic fastAtEnd;   // faster bank phase sits on its last count
    logic parityOk;    // in equal mode, the upcoming edge is a marked one
  } syncCtl_t;

endpackage

// File: rtl/coinc_sync_ctrl.sv
module coinc_sync_ctrl
  import coinc_sync_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] divA,
  input  logic [W-1:0] divC,
  input  logic [W-1:0] phaseA,
  input  logic [W-1:0] phaseC,
  output syncCtl_t     ctl
);

  localparam logic [W-1:0] ONE = W'(1);

  logic aIsFast;
  logic equalMode;
  logic fastAtEnd;
  logic edgeParity;

  assign aIsFast   = (divA <= divC);
  assign equalMode = (divA == divC);
  assign fastAtEnd = aIsFast ? (phaseA == divA - ONE) : (phaseC == divC - ONE);

  // Parity of the faster bank's rising edges since reset; the edge at reset is even
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeParity <= 1'b0;
    else       edgeParity <= edgeParity ^ fastAtEnd;
  end

  always_comb begin
    ctl.aIsFast   = aIsFast;
    ctl.equalMode = equalMode;
    ctl.fastAtEnd = fastAtEnd;
    // Parity of the next faster-bank edge: even when two edges lie ahead, odd when one does
    ctl.parityOk  = fastAtEnd ? ~edgeParity : edgeParity;
  end

  // R6: in equal mode the marked-edge parity flips on every bank edge
  assert_parity_flips_R6: assert property (@(posedge clk) disable iff (!rstN)
    (equalMode && fastAtEnd) |=> (edgeParity != $past(edgeParity)));

endmodule

// File: rtl/coinc_sync_dp.sv
module coinc_sync_dp
  import coinc_sync_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] divA,
  input  logic [W-1:0] divC,
  input  logic [W-1:0] phaseA,
  input  logic [W-1:0] phaseC,
  input  logic         freeze,
  input  syncCtl_t     ctl,
  output logic         syncN
);

  localparam int SW = W + 2;   // room for slow phase + lead, up to twice the slow ratio
  localparam int RW = W + 1;   // checker run-length width

  logic [W-1:0]  fastDiv, slowDiv, fastPh, slowPh;
  logic [SW-1:0] lead, total, slowExt;
  logic          hit, qualify;

  assign fastDiv = ctl.aIsFast ? divA   : divC;
  assign slowDiv = ctl.aIsFast ? divC   : divA;
  assign fastPh  = ctl.aIsFast ? phaseA : phaseC;
  assign slowPh  = ctl.aIsFast ? phaseC : phaseA;

  // Distance from this cycle to the faster bank's second-next rising edge horizon:
  // the next-cycle window ends on the first faster edge strictly after next cycle.
  assign lead    = ctl.fastAtEnd ? (SW'(fastDiv) + SW'(1)) : (SW'(fastDiv) - SW'(fastPh));
  assign total   = SW'(slowPh) + lead;
  assign slowExt = SW'(slowDiv);
  assign hit     = (total == slowExt) || (total == (slowExt << 1));
  assign qualify = hit && (!ctl.equalMode || ctl.parityOk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       syncN <= 1'b1;
    else if (freeze) syncN <= 1'b0;
    else             syncN <= ~qualify;
  end

  // Checker state: length of the current low run and whether a freeze touched it
  logic          freezeD1;
  logic [RW-1:0] runLen;
  logic          runFrozen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freezeD1  <= 1'b0;
      runLen    <= '0;
      runFrozen <= 1'b0;
    end else begin
      freezeD1 <= freeze;
      if (syncN) begin
        runLen    <= '0;
        runFrozen <= 1'b0;
      end else begin
        if (runLen != {RW{1'b1}}) runLen <= runLen + RW'(1);
        runFrozen <= runFrozen | freezeD1;
      end
    end
  end

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(syncN) && !runFrozen) |-> (runLen == RW'(fastDiv)));

  assert_rise_coincident_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(syncN) && !runFrozen) |-> (phaseA == '0 && phaseC == '0));

  assert_fall_on_fast_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(syncN) && !freezeD1) |-> (fastPh == '0));

  assert_freeze_holds_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> !syncN);

endmodule

// File: rtl/coinc_sync_gen.sv
module coinc_sync_gen
  import coinc_sync_pkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] divA,
  input  logic [W-1:0] divC,
  input  logic [W-1:0] phaseA,
  input  logic [W-1:0] phaseC,
  input  logic         freeze,
  output logic         syncN
);

  syncCtl_t ctl;

  coinc_sync_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .divA   (divA),
    .divC   (divC),
    .phaseA (phaseA),
    .phaseC (phaseC),
    .ctl    (ctl)
  );

  coinc_sync_dp #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .divA   (divA),
    .divC   (divC),
    .phaseA (phaseA),
    .phaseC (phaseC),
    .freeze (freeze),
    .ctl    (ctl),
    .syncN  (syncN)
  );

endmodule

// File: tb/coinc_sync_gen_tb.sv
module coinc_sync_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int WATCHDOG_CYCLES = 150000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] divA = W'(1);
  logic [W-1:0] divC = W'(1);
  logic [W-1:0] phaseA = '0;
  logic [W-1:0] phaseC = '0;
  logic         freeze = 1'b0;
  logic         syncN;

  int vecs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coinc_sync_gen #(.W(W)) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .divA   (divA),
    .divC   (divC),
    .phaseA (phaseA),
    .phaseC (phaseC),
    .freeze (freeze),
    .syncN  (syncN)
  );

  function automatic int gcd(int x, int y);
    int p = x;
    int q = y;
    while (q != 0) begin
      int r = p % q;
      p = q;
      q = r;
    end
    return p;
  endfunction

  task automatic check(logic got, logic exp, string req, int t, int a, int c);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d divA=%0d divC=%0d: syncN=%0b expected %0b",
               req, t, a, c, got, exp);
    end
  endtask

  // One configuration: reset, then run with a behavioural model of the expected pulse train
  task automatic runCase(int a, int c, int cycles, int fStart, int fLen);
    int  f;
    int  lc;
    logic prevFrz;
    logic exp;
    string req;
    @(negedge clk);
    rstN   = 1'b0;
    divA   = W'(a);
    divC   = W'(c);
    phaseA = '0;
    phaseC = '0;
    freeze = 1'b0;
    repeat (2) @(negedge clk);
    check(syncN, 1'b1, "R1", -1, a, c);     // R1: high during reset
    rstN = 1'b1;
    f  = (a < c) ? a : c;
    lc = (a == c) ? 2 * a : (a / gcd(a, c)) * c;
    #1;
    check(syncN, 1'b1, "R1", 0, a, c);      // R1: first cycle after release
    for (int t = 1; t <= cycles; t++) begin
      @(posedge clk);
      #1;
      prevFrz = freeze;
      phaseA  = W'(t % a);
      phaseC  = W'(t % c);
      freeze  = (t >= fStart) && (t < fStart + fLen);
      @(negedge clk);
      if (prevFrz) exp = 1'b0;
      else         exp = ((t % lc) >= (lc - f)) ? 1'b0 : 1'b1;
      if (prevFrz)                              req = "R7";
      else if (a == c)                          req = "R6";
      else if (exp && (t % lc) == 0)            req = "R3";
      else if (!exp && (t % lc) == (lc - f))    req = "R4";
      else if (a > c)                           req = "R8";
      else if (!exp)                            req = "R2";
      else                                      req = "R5";
      check(syncN, exp, req, t, a, c);
    end
  endtask

  initial begin
    runCase(4, 4, 120, 1000, 0);   // 1:1
    runCase(1, 1, 40, 1000, 0);    // 1:1 at source rate
    runCase(2, 4, 120, 1000, 0);   // 2:1
    runCase(2, 6, 120, 1000, 0);   // 3:1
    runCase(2, 3, 120, 1000, 0);   // 3:2
    runCase(3, 4, 150, 1000, 0);   // 4:3
    runCase(2, 8, 120, 1000, 0);   // 4:1
    runCase(1, 6, 60, 1000, 0);    // 6:1
    runCase(3, 2, 120, 1000, 0);   // R8: C faster, 3:2
    runCase(4, 3, 150, 1000, 0);   // R8: C faster, 4:3
    runCase(7, 5, 200, 1000, 0);   // R8: coprime ratio
    runCase(4, 6, 200, 50, 30);    // R7: freeze mid-run, then release
    runCase(3, 3, 80, 20, 7);      // R7: freeze in 1:1 mode
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung after %0d vectors, expected completion", vecs);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule